// File: doc/BRIEF.md
# Multi-Record Triggered Capture Controller

This block records a stream of 32-bit samples into a set of fixed-size records held in on-chip RAM. A session is opened with an arm command, which also freezes the record length, the post-trigger sample count and the number of records. A start trigger opens the first record. While a record is open, every valid sample goes into it as a circular buffer, so history before the point of interest is kept. A reference trigger marks that point. The block then takes a programmed number of further samples and closes the record. Each later record is opened by an advance trigger.

For each record the block keeps a metadata entry. It holds the write offset of the first post-trigger sample, the value of a free-running 64-bit cycle counter taken when the reference trigger was accepted, and a flag that says the record was finished. A consumer reads any word of any record through a simple registered read port. It uses the completed-record count to know which records are safe to read. An abort input drops the session and leaves the open record flagged unfinished.

A build-time parameter selects one or two samples per clock. With two, the data word is 64 bits wide under the same valid qualifier.

Top module: `mrec_capture`

## Requirements
- R1: After reset `busy` and `done` are low and `recsDone` is zero.
- R2: `arm` is honoured only while idle. It latches `cfgRecLen`, `cfgPostCnt` and `cfgNumRecs`, clears `recsDone` and `done`, and raises `busy`. Changes to these inputs, and `arm` pulses, have no effect while `busy` is high.
- R3: `startTrig` is honoured only while waiting for the first record. The sample on the trigger cycle is not stored, and the first valid sample after it lands at offset 0.
- R4: Before the reference trigger, every valid sample is written at the next offset of the record. The offset wraps from `recLen-1` to 0. Cycles with `inValid` low write nothing.
- R5: `refTrig` is honoured only in the pre-trigger phase of an open record. On acceptance, the stored reference offset is the offset that the next valid sample after the trigger cycle receives. A sample valid on the trigger cycle is still a pre-trigger sample.
- R6: After acceptance, the record closes on the `cfgPostCnt`-th valid sample. Idle cycles are not counted. With a count of 0 the record closes in the trigger cycle itself. Each closed record sets its metadata finished flag and adds one to `recsDone`.
- R7: After a record closes, the block waits for `advTrig`. An advance trigger is honoured only in that wait, so one in the closing cycle is ignored. Its own cycle's sample is not stored, and the next record starts at offset 0.
- R8: When the record numbered `cfgNumRecs` closes, `busy` falls and `done` rises. `done` stays high until the next accepted `arm`.
- R9: `abort` while busy returns the block to idle with `done` low and `recsDone` unchanged, and the open record's finished flag reads 0. `abort` while idle is ignored, and `arm` in the same idle cycle is still taken.
- R10: `rdData` returns the word stored at record `rdRec`, offset `rdOff`, one clock after the address is presented. `rdMetaOk`, `rdRefAddr` and `rdStamp` for record `rdRec` arrive on the same cycle.
- R11: The stored timestamp equals the number of rising clock edges between reset release and the edge at which the reference trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Open a new session (idle only) |
| abort | input | 1 | Drop the session and return to idle |
| cfgRecLen | input | REC_LOG2+1 | Record length in words, 1 to 2^REC_LOG2 |
| cfgPostCnt | input | REC_LOG2 | Post-trigger words, at most cfgRecLen-1 |
| cfgNumRecs | input | IDX_W+1 | Records per session, 1 to MAX_RECS |
| startTrig | input | 1 | Opens the first record |
| refTrig | input | 1 | Marks the point of interest |
| advTrig | input | 1 | Opens each later record |
| inValid | input | 1 | Qualifies inData |
| inData | input | 32*SAMPLES_PER_CLK | Sample word |
| rdRec | input | IDX_W | Record to read |
| rdOff | input | REC_LOG2 | Word offset in that record |
| rdData | output | 32*SAMPLES_PER_CLK | Stored word, one cycle later |
| rdMetaOk | output | 1 | Record was finished |
| rdRefAddr | output | REC_LOG2 | Offset of first post-trigger word |
| rdStamp | output | 64 | Timestamp at reference trigger |
| recsDone | output | IDX_W+1 | Records finished in this session |
| busy | output | 1 | Session in progress |
| done | output | 1 | All records finished |

## Verification
Two events can meet in one cycle: the last post-trigger sample that closes a record, and an advance trigger. The bench drives `advTrig` high on the exact closing cycle. It then feeds valid samples with start, reference and arm pulses during the wait. A lone advance trigger follows. The second record must start at offset 0 with none of the wait-phase words in it, and `recsDone` must stay at one through the wait. A second meeting is `abort` with `arm` while idle: the new session must open.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_START,
    ST_PRE,
    ST_POST,
    ST_WAIT_ADV
  } acqState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic wrEn;       // store inData at the current write offset
    logic recStart;   // rewind write offset, clear finished flag
    logic refHit;     // capture timestamp and reference offset
    logic recFinish;  // mark current record finished
  } acqStrobe_t;

endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int REC_LOG2 = 4,
  parameter int MAX_RECS = 4,
  localparam int IDX_W = $clog2(MAX_RECS),
  localparam int CNT_W = IDX_W + 1,
  localparam int LEN_W = REC_LOG2 + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                arm,
  input  logic                abort,
  input  logic [LEN_W-1:0]    cfgRecLen,
  input  logic [REC_LOG2-1:0] cfgPostCnt,
  input  logic [CNT_W-1:0]    cfgNumRecs,
  input  logic                startTrig,
  input  logic                refTrig,
  input  logic                advTrig,
  input  logic                inValid,
  output acqStrobe_t          strobe,
  output logic [IDX_W-1:0]    recIdx,
  output logic [LEN_W-1:0]    recLen,
  output logic [CNT_W-1:0]    recsDone,
  output logic                busy,
  output logic                done
);

  acqState_t state, nextState;
  logic [REC_LOG2-1:0] postCfg;
  logic [REC_LOG2-1:0] postLeft;
  logic [CNT_W-1:0]    numRecs;
  logic                lastRec;

  assign lastRec = (({1'b0, recIdx} + CNT_W'(1)) == numRecs);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (arm) nextState = ST_WAIT_START;
      end
      ST_WAIT_START: begin
        if (startTrig) begin
          strobe.recStart = 1'b1;
          nextState       = ST_PRE;
        end
      end
      ST_PRE: begin
        strobe.wrEn = inValid;
        if (refTrig) begin
          strobe.refHit = 1'b1;
          if (postCfg == '0) begin
            strobe.recFinish = 1'b1;
            nextState        = lastRec ? ST_IDLE : ST_WAIT_ADV;
          end else begin
            nextState = ST_POST;
          end
        end
      end
      ST_POST: begin
        strobe.wrEn = inValid;
        if (inValid && postLeft == REC_LOG2'(1)) begin
          strobe.recFinish = 1'b1;
          nextState        = lastRec ? ST_IDLE : ST_WAIT_ADV;
        end
      end
      ST_WAIT_ADV: begin
        if (advTrig) begin
          strobe.recStart = 1'b1;
          nextState       = ST_PRE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (abort && state != ST_IDLE) begin
      strobe    = '0;
      nextState = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      recIdx   <= '0;
      recLen   <= '0;
      postCfg  <= '0;
      postLeft <= '0;
      numRecs  <= '0;
      recsDone <= '0;
      done     <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && arm) begin
        recLen   <= cfgRecLen;
        postCfg  <= cfgPostCnt;
        numRecs  <= cfgNumRecs;
        recIdx   <= '0;
        recsDone <= '0;
        done     <= 1'b0;
      end
      if (strobe.refHit) begin
        postLeft <= postCfg;
      end else if (state == ST_POST && inValid) begin
        postLeft <= postLeft - 1'b1;
      end
      if (strobe.recFinish) begin
        recsDone <= recsDone + 1'b1;
        if (lastRec) done   <= 1'b1;
        else         recIdx <= recIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/acq_datapath.sv
module acq_datapath
  import acq_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int REC_LOG2 = 4,
  parameter int MAX_RECS = 4,
  parameter int TS_W     = 64,
  localparam int IDX_W   = $clog2(MAX_RECS),
  localparam int LEN_W   = REC_LOG2 + 1,
  localparam int ADDR_W  = IDX_W + REC_LOG2,
  localparam int DEPTH   = 1 << ADDR_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  acqStrobe_t          strobe,
  input  logic [IDX_W-1:0]    recIdx,
  input  logic [LEN_W-1:0]    recLen,
  input  logic [WORD_W-1:0]   inData,
  input  logic [IDX_W-1:0]    rdRec,
  input  logic [REC_LOG2-1:0] rdOff,
  output logic [WORD_W-1:0]   rdData,
  output logic                rdMetaOk,
  output logic [REC_LOG2-1:0] rdRefAddr,
  output logic [TS_W-1:0]     rdStamp
);

  logic [WORD_W-1:0]   sampleMem [DEPTH];
  logic [REC_LOG2-1:0] refMem    [MAX_RECS];
  logic [TS_W-1:0]     stampMem  [MAX_RECS];
  logic [MAX_RECS-1:0] metaOk;
  logic [REC_LOG2-1:0] wrPtr, nextPtr;
  logic [TS_W-1:0]     tsCnt;

  // circular advance inside the record slot
  assign nextPtr = (({1'b0, wrPtr} + LEN_W'(1)) == recLen) ? '0 : wrPtr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      tsCnt  <= '0;
      metaOk <= '0;
    end else begin
      tsCnt <= tsCnt + 1'b1;
      if (strobe.recStart)  wrPtr <= '0;
      else if (strobe.wrEn) wrPtr <= nextPtr;
      if (strobe.recStart)  metaOk[recIdx] <= 1'b0;
      if (strobe.recFinish) metaOk[recIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) sampleMem[{recIdx, wrPtr}] <= inData;
    if (strobe.refHit) begin
      refMem[recIdx]   <= strobe.wrEn ? nextPtr : wrPtr;
      stampMem[recIdx] <= tsCnt;
    end
  end

  always_ff @(posedge clk) begin
    rdData    <= sampleMem[{rdRec, rdOff}];
    rdRefAddr <= refMem[rdRec];
    rdStamp   <= stampMem[rdRec];
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdMetaOk <= 1'b0;
    else       rdMetaOk <= metaOk[rdRec];
  end

endmodule

// File: rtl/mrec_capture.sv
module mrec_capture
  import acq_pkg::*;
#(
  parameter int SAMPLES_PER_CLK = 1,
  parameter int REC_LOG2        = 4,
  parameter int MAX_RECS        = 4,
  localparam int WORD_W = 32 * SAMPLES_PER_CLK,
  localparam int IDX_W  = $clog2(MAX_RECS),
  localparam int CNT_W  = IDX_W + 1,
  localparam int LEN_W  = REC_LOG2 + 1,
  localparam int TS_W   = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                arm,
  input  logic                abort,
  input  logic [LEN_W-1:0]    cfgRecLen,
  input  logic [REC_LOG2-1:0] cfgPostCnt,
  input  logic [CNT_W-1:0]    cfgNumRecs,
  input  logic                startTrig,
  input  logic                refTrig,
  input  logic                advTrig,
  input  logic                inValid,
  input  logic [WORD_W-1:0]   inData,
  input  logic [IDX_W-1:0]    rdRec,
  input  logic [REC_LOG2-1:0] rdOff,
  output logic [WORD_W-1:0]   rdData,
  output logic                rdMetaOk,
  output logic [REC_LOG2-1:0] rdRefAddr,
  output logic [TS_W-1:0]     rdStamp,
  output logic [CNT_W-1:0]    recsDone,
  output logic                busy,
  output logic                done
);

  acqStrobe_t       strobe;
  logic [IDX_W-1:0] recIdx;
  logic [LEN_W-1:0] recLen;

  acq_ctrl #(.REC_LOG2(REC_LOG2), .MAX_RECS(MAX_RECS)) u_ctrl (
    .clk(clk), .rstN(rstN), .arm(arm), .abort(abort),
    .cfgRecLen(cfgRecLen), .cfgPostCnt(cfgPostCnt), .cfgNumRecs(cfgNumRecs),
    .startTrig(startTrig), .refTrig(refTrig), .advTrig(advTrig),
    .inValid(inValid), .strobe(strobe), .recIdx(recIdx), .recLen(recLen),
    .recsDone(recsDone), .busy(busy), .done(done)
  );

  acq_datapath #(
    .WORD_W(WORD_W), .REC_LOG2(REC_LOG2), .MAX_RECS(MAX_RECS), .TS_W(TS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .recIdx(recIdx), .recLen(recLen),
    .inData(inData), .rdRec(rdRec), .rdOff(rdOff), .rdData(rdData),
    .rdMetaOk(rdMetaOk), .rdRefAddr(rdRefAddr), .rdStamp(rdStamp)
  );

endmodule

// File: rtl/mrec_capture_chk.sv
module mrec_capture_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             arm,
  input logic             abort,
  input logic [CNT_W-1:0] recsDone,
  input logic             busy,
  input logic             done
);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(busy) && recsDone != '0));

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(arm));

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abort && busy) |=> (!busy && !done));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (recsDone != $past(recsDone)) |->
      (recsDone == $past(recsDone) + CNT_W'(1) || recsDone == '0));

endmodule

bind mrec_capture mrec_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .arm(arm), .abort(abort),
  .recsDone(recsDone), .busy(busy), .done(done)
);

// File: tb/tb_mrec_capture.sv
module tb_mrec_capture;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        arm = 1'b0, abort = 1'b0;
  logic [4:0]  cfgRecLen = '0;
  logic [3:0]  cfgPostCnt = '0;
  logic [2:0]  cfgNumRecs = '0;
  logic        startTrig = 1'b0, refTrig = 1'b0, advTrig = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic [1:0]  rdRec = '0;
  logic [3:0]  rdOff = '0;
  logic [31:0] rdData;
  logic        rdMetaOk;
  logic [3:0]  rdRefAddr;
  logic [63:0] rdStamp;
  logic [2:0]  recsDone;
  logic        busy, done;

  int total = 0;
  int bad = 0;
  longint unsigned tbCyc;
  longint unsigned stamp0, stamp1, stamp2;

  typedef struct {
    logic [31:0] expData;
    bit          chkOk;
    logic        expOk;
    int          okReq;
    bit          chkRef;
    logic [3:0]  expRef;
    logic [63:0] expStamp;
  } rdItem_t;

  rdItem_t rdQ[$];

  mrec_capture dut (
    .clk(clk), .rstN(rstN), .arm(arm), .abort(abort),
    .cfgRecLen(cfgRecLen), .cfgPostCnt(cfgPostCnt), .cfgNumRecs(cfgNumRecs),
    .startTrig(startTrig), .refTrig(refTrig), .advTrig(advTrig),
    .inValid(inValid), .inData(inData), .rdRec(rdRec), .rdOff(rdOff),
    .rdData(rdData), .rdMetaOk(rdMetaOk), .rdRefAddr(rdRefAddr),
    .rdStamp(rdStamp), .recsDone(recsDone), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // edges since reset release (R11)
  always @(posedge clk) begin
    if (!rstN) tbCyc <= 0;
    else       tbCyc <= tbCyc + 1;
  end

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one stimulus cycle: inputs change at a falling edge
  task automatic step(input bit v, input logic [31:0] d, input bit st, input bit rf,
                      input bit ad, input bit ar, input bit ab);
    inValid = v; inData = d; startTrig = st; refTrig = rf; advTrig = ad;
    arm = ar; abort = ab;
    @(negedge clk);
  endtask

  task automatic quiet();
    step(0, 32'h0, 0, 0, 0, 0, 0);
  endtask

  // driver: present address, push the expectation for the monitor
  task automatic rdChk(input int rec, input int off, input logic [31:0] d,
                       input bit cOk, input logic eOk, input int okReq,
                       input bit cRef, input logic [3:0] eRef, input logic [63:0] eSt);
    rdItem_t it;
    it.expData = d; it.chkOk = cOk; it.expOk = eOk; it.okReq = okReq;
    it.chkRef = cRef; it.expRef = eRef; it.expStamp = eSt;
    rdRec = 2'(rec); rdOff = 4'(off);
    rdQ.push_back(it);
    @(negedge clk);
  endtask

  // monitor: result registered on the edge after the address (R10)
  always @(posedge clk) begin
    if (rdQ.size() > 0) begin
      rdItem_t it;
      it = rdQ.pop_front();
      #2;
      chk(rdData === it.expData, "R10 data", rdData, it.expData);
      if (it.chkOk)
        chk(rdMetaOk === it.expOk, $sformatf("R%0d metaOk", it.okReq), rdMetaOk, it.expOk);
      if (it.chkRef) begin
        chk(rdRefAddr === it.expRef, "R5 refAddr", rdRefAddr, it.expRef);
        chk(rdStamp === it.expStamp, "R11 stamp", rdStamp, it.expStamp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rec0 [8];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(busy == 0 && done == 0 && recsDone == 0, "R1 reset", {busy, done, recsDone}, 0);

    // idle: start and reference pulses do nothing (R3)
    step(1, 32'hDEAD0000, 1, 1, 0, 0, 0);
    quiet();
    chk(busy == 0, "R3 start ignored in idle", busy, 0);

    // session 1: len 8, post 3, two records
    cfgRecLen = 5'd8; cfgPostCnt = 4'd3; cfgNumRecs = 3'd2;
    step(0, 0, 0, 0, 0, 1, 0);
    // R2
    chk(busy == 1 && done == 0 && recsDone == 0, "R2 arm", {busy, done, recsDone}, 3'b100);
    cfgRecLen = 5'd4; cfgPostCnt = 4'd1; cfgNumRecs = 3'd1;   // must be ignored (R2)
    step(1, 32'hDEAD0001, 0, 1, 1, 0, 0);   // ref/adv before start ignored (R5, R7)
    step(1, 32'hDEAD0002, 1, 0, 0, 0, 0);   // start, own sample not stored (R3)
    for (int j = 0; j < 10; j++) begin
      if (j == 9) stamp0 = tbCyc;
      step(1, 32'h100 + 32'(j), 0, j == 9, 0, 0, 0);   // R4 pre-trigger writes
    end
    step(1, 32'h10A, 0, 1, 0, 0, 0);        // second ref ignored (R5)
    step(0, 32'hDEAD0005, 0, 0, 0, 0, 0);   // idle cycle not counted (R6)
    step(1, 32'h10B, 0, 0, 0, 0, 0);
    chk(recsDone == 0, "R6 not yet closed", recsDone, 0);
    step(1, 32'h10C, 0, 0, 1, 0, 0);        // closes, advance in same cycle (R7)
    chk(recsDone == 1 && busy == 1 && done == 0, "R6 record closed", {busy, done, recsDone}, 3'b100 + 1);
    step(1, 32'hDEAD0003, 1, 1, 0, 0, 0);
    step(1, 32'hDEAD0006, 0, 0, 0, 1, 0);   // arm while busy ignored (R2)
    chk(recsDone == 1 && busy == 1, "R7 no advance yet / R2 arm ignored", recsDone, 1);
    step(1, 32'hDEAD0004, 0, 0, 1, 0, 0);   // advance
    for (int j = 0; j < 3; j++) step(1, 32'h200 + 32'(j), 0, 0, 0, 0, 0);
    stamp1 = tbCyc;
    step(0, 32'hDEAD0007, 0, 1, 0, 0, 0);   // ref with no sample: ref offset 3
    step(1, 32'h203, 0, 0, 0, 0, 0);
    step(0, 32'hDEAD0008, 0, 0, 0, 0, 0);
    step(1, 32'h204, 0, 0, 0, 0, 0);
    step(1, 32'h205, 0, 0, 0, 0, 0);
    quiet();
    // R8
    chk(done == 1 && busy == 0 && recsDone == 2, "R8 session end", {busy, done, recsDone}, 3'b010 + 2);
    step(1, 32'hDEAD0009, 1, 0, 0, 0, 0);
    quiet();
    chk(busy == 0 && done == 1, "R8 done held / R3 start ignored", {busy, done}, 1);

    // readback session 1 (R4, R5, R10, R11)
    rec0[0] = 32'h108; rec0[1] = 32'h109; rec0[2] = 32'h10A; rec0[3] = 32'h10B;
    rec0[4] = 32'h10C; rec0[5] = 32'h105; rec0[6] = 32'h106; rec0[7] = 32'h107;
    for (int k = 0; k < 8; k++) rdChk(0, k, rec0[k], 1, 1, 6, 1, 4'd2, stamp0);
    for (int k = 0; k < 6; k++) rdChk(1, k, 32'h200 + 32'(k), 1, 1, 6, 1, 4'd3, stamp1);
    quiet(); quiet();

    // session 2: len 4, post 0, three records; abort with arm in idle (R9)
    cfgRecLen = 5'd4; cfgPostCnt = 4'd0; cfgNumRecs = 3'd3;
    step(0, 0, 0, 0, 0, 1, 1);
    chk(busy == 1 && done == 0 && recsDone == 0, "R9 arm wins in idle / R8 done cleared",
        {busy, done, recsDone}, 3'b100);
    step(0, 0, 1, 0, 0, 0, 0);
    for (int j = 0; j < 5; j++) begin
      if (j == 4) stamp2 = tbCyc;
      step(1, 32'h300 + 32'(j), 0, j == 4, 0, 0, 0);
    end
    chk(recsDone == 1 && busy == 1, "R6 post count zero closes on trigger", recsDone, 1);
    step(0, 0, 0, 0, 1, 0, 0);
    step(1, 32'h400, 0, 0, 0, 0, 0);
    step(1, 32'h401, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    // R9
    chk(busy == 0 && done == 0 && recsDone == 1, "R9 abort", {busy, done, recsDone}, 1);

    rdChk(0, 0, 32'h304, 1, 1, 6, 1, 4'd1, stamp2);
    rdChk(0, 1, 32'h301, 0, 0, 0, 0, 0, 0);
    rdChk(0, 2, 32'h302, 0, 0, 0, 0, 0, 0);
    rdChk(0, 3, 32'h303, 0, 0, 0, 0, 0, 0);
    rdChk(1, 0, 32'h400, 1, 0, 9, 0, 0, 0);
    rdChk(1, 1, 32'h401, 1, 0, 9, 0, 0, 0);
    quiet(); quiet();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule